// File: doc/BRIEF.md
# Direct Segment Address Translator

This block is a per-core translation unit placed beside a conventional TLB. Software programs three registers: a segment start, a segment end and a translation offset. Every virtual address that is accepted is compared against the segment window. An address inside the window is translated by adding the offset, and the TLB is never consulted for it. Any other address becomes a request on the TLB port, and the answer that comes back, including its fault flag, is passed on as the translation response.

Software can take memory back from the segment and return it to paging at run time. Programming the end register equal to the start register, or below it, empties the window, and then every request takes the paging path. One translation is in flight at a time, so responses come back in the order the requests were made. A segment hit answers on the cycle after acceptance. A TLB-routed request answers on the cycle after the TLB responds.

Top module: `dseg_xlate`

## Requirements
- R1: After reset the start, end and offset registers are all zero, so the window is empty. `rsp_valid` and `tlb_req_valid` are low, `req_ready` is high, and the first request of any address goes to the TLB.
- R2: An accepted address `va` with start <= va < end, compared unsigned, is a segment hit. Its response carries `rsp_pa` = (va zero-extended + offset) mod 2^PA_W, `rsp_seg_hit`=1 and `rsp_fault`=0.
- R3: An accepted address outside the window raises `tlb_req_valid` with `tlb_req_va` equal to that address. The request holds stable until `tlb_req_ready`. The following `tlb_rsp_pa` and `tlb_rsp_fault` appear on `rsp_pa` and `rsp_fault` with `rsp_seg_hit`=0.
- R4: A segment hit never asserts `tlb_req_valid`.
- R5: When end <= start the window is empty, and every address is routed to the TLB.
- R6: A register write takes effect for requests accepted from the next cycle onward. A request accepted in the same cycle as a write is translated with the old values.
- R7: A hit response appears exactly one cycle after acceptance, and hits may be accepted back to back, one per cycle.
- R8: While a TLB-routed request is outstanding, `req_ready` is low. Exactly one response is produced per accepted request, in acceptance order. `tlb_rsp_valid` is ignored unless a TLB request has been handed over.
- R9: Segment hits are always read-write permitted: `rsp_fault` is 0 on every hit response.
- R10: Write select encoding: `cfg_sel`=0 writes the start register (low VA_W bits of `cfg_wdata`), 1 writes the end register (low VA_W bits), 2 writes the offset (PA_W bits), and 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 start, 1 end, 2 offset, 3 none) |
| cfg_wdata | input | PA_W | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_va | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Translation response valid (one cycle) |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_seg_hit | output | 1 | Response came from the segment |
| rsp_fault | output | 1 | Fault from the paging path |
| tlb_req_valid | output | 1 | Request to the TLB |
| tlb_req_ready | input | 1 | TLB accepts the request |
| tlb_req_va | output | VA_W | Address sent to the TLB |
| tlb_rsp_valid | input | 1 | TLB response valid |
| tlb_rsp_pa | input | PA_W | TLB physical address |
| tlb_rsp_fault | input | 1 | TLB fault flag |

## Verification
A corrupted start, end or offset register shows up on the very next request near a window edge. The next cycle then brings either a wrong `rsp_pa` or a TLB request where a one-cycle hit was due, or the reverse. A stuck routing state shows up as `req_ready` staying low, or as a missing or duplicated response, within one TLB round trip. Sweeping every address of a narrow configuration across several windows, including empty and inverted ones and offsets that wrap, exposes an off-by-one at either window edge and a lost carry in the addition.

// File: rtl/dseg_pkg.sv
package dseg_pkg;

   typedef enum logic [1:0] {
      SEL_START  = 2'd0,
      SEL_END    = 2'd1,
      SEL_OFFSET = 2'd2,
      SEL_NONE   = 2'd3
   } dseg_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } dseg_state_e;

endpackage

// File: rtl/dseg_regs.sv
module dseg_regs
   import dseg_pkg::*;
#(
   parameter int VA_W = 48,
   parameter int PA_W = 52
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_sel,
   input  logic [PA_W-1:0] cfg_wdata,
   output logic [VA_W-1:0] seg_start,
   output logic [VA_W-1:0] seg_end,
   output logic [PA_W-1:0] seg_offset
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_start  <= '0;
         seg_end    <= '0;
         seg_offset <= '0;
      end else if (cfg_we) begin
         case (dseg_sel_e'(cfg_sel))
            SEL_START:  seg_start  <= cfg_wdata[VA_W-1:0];
            SEL_END:    seg_end    <= cfg_wdata[VA_W-1:0];
            SEL_OFFSET: seg_offset <= cfg_wdata;
            default: ;
         endcase
      end
   end

   // R10: select value 3 leaves every register untouched
   a_r10_sel_none_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 2'd3) |=> ($stable(seg_start) && $stable(seg_end) && $stable(seg_offset)));

endmodule

// File: rtl/dseg_match.sv
module dseg_match #(
   parameter int VA_W = 48,
   parameter int PA_W = 52
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [VA_W-1:0] va,
   input  logic [VA_W-1:0] seg_start,
   input  logic [VA_W-1:0] seg_end,
   input  logic [PA_W-1:0] seg_offset,
   output logic            hit,
   output logic [PA_W-1:0] pa
);

   localparam int EXT_W = PA_W - VA_W;

   logic [PA_W-1:0] va_ext;
   logic            above_start;
   logic            below_end;

   generate
      if (EXT_W == 0) begin : g_same_width
         assign va_ext = va;
      end else begin : g_zero_ext
         assign va_ext = {{EXT_W{1'b0}}, va};
      end
   endgenerate

   assign above_start = (va >= seg_start);
   assign below_end   = (va < seg_end);
   assign hit         = above_start && below_end;
   assign pa          = va_ext + seg_offset;

   // R5: an empty or inverted window never matches
   a_r5_empty_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_end <= seg_start) |-> !hit);

endmodule

// File: rtl/dseg_route.sv
module dseg_route
   import dseg_pkg::*;
#(
   parameter int VA_W = 48,
   parameter int PA_W = 52
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_va,
   input  logic            seg_hit,
   input  logic [PA_W-1:0] seg_pa,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_pa,
   output logic            rsp_seg_hit,
   output logic            rsp_fault,
   output logic            tlb_req_valid,
   input  logic            tlb_req_ready,
   output logic [VA_W-1:0] tlb_req_va,
   input  logic            tlb_rsp_valid,
   input  logic [PA_W-1:0] tlb_rsp_pa,
   input  logic            tlb_rsp_fault
);

   dseg_state_e     state_q;
   logic [VA_W-1:0] miss_va_q;
   logic            req_fire;

   assign req_ready     = (state_q == ST_IDLE);
   assign req_fire      = req_valid && req_ready;
   assign tlb_req_valid = (state_q == ST_ISSUE);
   assign tlb_req_va    = miss_va_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         miss_va_q   <= '0;
         rsp_valid   <= 1'b0;
         rsp_pa      <= '0;
         rsp_seg_hit <= 1'b0;
         rsp_fault   <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_fire) begin
                  if (seg_hit) begin
                     rsp_valid   <= 1'b1;
                     rsp_pa      <= seg_pa;
                     rsp_seg_hit <= 1'b1;
                     rsp_fault   <= 1'b0;
                  end else begin
                     miss_va_q <= req_va;
                     state_q   <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (tlb_req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (tlb_rsp_valid) begin
                  rsp_valid   <= 1'b1;
                  rsp_pa      <= tlb_rsp_pa;
                  rsp_seg_hit <= 1'b0;
                  rsp_fault   <= tlb_rsp_fault;
                  state_q     <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R7: a hit answers on the next cycle from the segment
   a_r7_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && seg_hit) |=> (rsp_valid && rsp_seg_hit));

   // R4: a hit never produces a TLB request
   a_r4_hit_no_tlb: assert property (@(posedge clk) disable iff (!rst_n)
      (req_fire && seg_hit) |=> !tlb_req_valid);

   // R9: hit responses never carry a fault
   a_r9_hit_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_seg_hit) |-> !rsp_fault);

   // R3: a pending TLB request holds its address until taken
   a_r3_tlb_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tlb_req_valid && !tlb_req_ready) |=> (tlb_req_valid && $stable(tlb_req_va)));

   // R8: nothing new is accepted while a TLB request is pending
   a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid |-> !req_ready);

   // R3: a TLB response becomes the translation response
   a_r3_tlb_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !tlb_req_valid && tlb_rsp_valid) |=> (rsp_valid && !rsp_seg_hit && req_ready));

endmodule

// File: rtl/dseg_xlate.sv
module dseg_xlate #(
   parameter int VA_W = 48,
   parameter int PA_W = 52
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_sel,
   input  logic [PA_W-1:0] cfg_wdata,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_va,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_pa,
   output logic            rsp_seg_hit,
   output logic            rsp_fault,
   output logic            tlb_req_valid,
   input  logic            tlb_req_ready,
   output logic [VA_W-1:0] tlb_req_va,
   input  logic            tlb_rsp_valid,
   input  logic [PA_W-1:0] tlb_rsp_pa,
   input  logic            tlb_rsp_fault
);

   generate
      if (VA_W < 2) begin : g_bad_va
         $error("dseg_xlate: VA_W must be at least 2");
      end
      if (PA_W < VA_W) begin : g_bad_pa
         $error("dseg_xlate: PA_W must not be narrower than VA_W");
      end
   endgenerate

   logic [VA_W-1:0] seg_start;
   logic [VA_W-1:0] seg_end;
   logic [PA_W-1:0] seg_offset;
   logic            seg_hit;
   logic [PA_W-1:0] seg_pa;

   dseg_regs #(.VA_W(VA_W), .PA_W(PA_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .seg_start  (seg_start),
      .seg_end    (seg_end),
      .seg_offset (seg_offset)
   );

   dseg_match #(.VA_W(VA_W), .PA_W(PA_W)) match_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .va         (req_va),
      .seg_start  (seg_start),
      .seg_end    (seg_end),
      .seg_offset (seg_offset),
      .hit        (seg_hit),
      .pa         (seg_pa)
   );

   dseg_route #(.VA_W(VA_W), .PA_W(PA_W)) route_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_va        (req_va),
      .seg_hit       (seg_hit),
      .seg_pa        (seg_pa),
      .rsp_valid     (rsp_valid),
      .rsp_pa        (rsp_pa),
      .rsp_seg_hit   (rsp_seg_hit),
      .rsp_fault     (rsp_fault),
      .tlb_req_valid (tlb_req_valid),
      .tlb_req_ready (tlb_req_ready),
      .tlb_req_va    (tlb_req_va),
      .tlb_rsp_valid (tlb_rsp_valid),
      .tlb_rsp_pa    (tlb_rsp_pa),
      .tlb_rsp_fault (tlb_rsp_fault)
   );

endmodule

// File: tb/dseg_xlate_tb.sv
module dseg_xlate_tb_top;

   localparam int VA_W     = 6;
   localparam int PA_W     = 8;
   localparam int CLK_PER  = 10;
   localparam int WD_LIMIT = 150000;
   localparam int NVA      = 1 << VA_W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_sel = '0;
   logic [PA_W-1:0] cfg_wdata = '0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [VA_W-1:0] req_va = '0;
   logic            rsp_valid;
   logic [PA_W-1:0] rsp_pa;
   logic            rsp_seg_hit;
   logic            rsp_fault;
   logic            tlb_req_valid;
   logic            tlb_req_ready = 1'b0;
   logic [VA_W-1:0] tlb_req_va;
   logic            tlb_rsp_valid = 1'b0;
   logic [PA_W-1:0] tlb_rsp_pa = '0;
   logic            tlb_rsp_fault = 1'b0;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   // model of the programmed window
   int m_start = 0;
   int m_end   = 0;
   int m_off   = 0;

   always #(CLK_PER/2) clk = ~clk;

   dseg_xlate #(.VA_W(VA_W), .PA_W(PA_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_seg_hit(rsp_seg_hit), .rsp_fault(rsp_fault),
      .tlb_req_valid(tlb_req_valid), .tlb_req_ready(tlb_req_ready), .tlb_req_va(tlb_req_va),
      .tlb_rsp_valid(tlb_rsp_valid), .tlb_rsp_pa(tlb_rsp_pa), .tlb_rsp_fault(tlb_rsp_fault)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT) begin
         $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WD_LIMIT);
         bad = bad + 1;
         total = total + 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input int sel, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = data[PA_W-1:0];
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         0: m_start = data % NVA;
         1: m_end   = data % NVA;
         2: m_off   = data % (1 << PA_W);
         default: ;
      endcase
   endtask

   function automatic bit exp_hit(input int va);
      return (va >= m_start) && (va < m_end);
   endfunction

   function automatic int tlb_pa(input int va);
      return (va * 3 + 17) % (1 << PA_W);
   endfunction

   // issue one request; caller has it at negedge with design idle
   task automatic xlate(input int va, input int lat_rdy, input int lat_rsp);
      bit h;
      int epa;
      h = exp_hit(va);
      epa = (va + m_off) % (1 << PA_W);
      @(negedge clk);
      check(req_ready == 1'b1, "R8 ready when idle", req_ready, 1);
      req_valid = 1'b1; req_va = va[VA_W-1:0];
      @(negedge clk);
      req_valid = 1'b0;
      if (h) begin
         check(rsp_valid && rsp_seg_hit, "R7 hit rsp next cycle", {rsp_valid, rsp_seg_hit}, 3);
         check(rsp_pa == epa[PA_W-1:0], "R2 hit pa", rsp_pa, epa);
         check(rsp_fault == 1'b0, "R9 hit no fault", rsp_fault, 0);
         check(tlb_req_valid == 1'b0, "R4 hit no tlb req", tlb_req_valid, 0);
      end else begin
         check(rsp_valid == 1'b0, "R3 miss no early rsp", rsp_valid, 0);
         check(tlb_req_valid == 1'b1, "R3 miss tlb req", tlb_req_valid, 1);
         check(tlb_req_va == va[VA_W-1:0], "R3 miss tlb va", tlb_req_va, va);
         // spurious TLB response before hand-over must be ignored (R8)
         tlb_rsp_valid = 1'b1; tlb_rsp_pa = 8'hEE;
         for (int i = 0; i < lat_rdy; i++) begin
            @(negedge clk);
            check(tlb_req_valid && tlb_req_va == va[VA_W-1:0] && !rsp_valid,
                  "R3 tlb req held", tlb_req_va, va);
            check(req_ready == 1'b0, "R8 busy blocks", req_ready, 0);
         end
         tlb_rsp_valid = 1'b0;
         tlb_req_ready = 1'b1;
         @(negedge clk);
         tlb_req_ready = 1'b0;
         check(tlb_req_valid == 1'b0 && req_ready == 1'b0, "R8 waiting", tlb_req_valid, 0);
         for (int i = 0; i < lat_rsp; i++) begin
            @(negedge clk);
            check(rsp_valid == 1'b0 && req_ready == 1'b0, "R8 no rsp yet", rsp_valid, 0);
         end
         tlb_rsp_valid = 1'b1;
         tlb_rsp_pa = tlb_pa(va);
         tlb_rsp_fault = va[0];
         @(negedge clk);
         tlb_rsp_valid = 1'b0;
         check(rsp_valid && !rsp_seg_hit, "R3 tlb rsp forwarded", {rsp_valid, rsp_seg_hit}, 2);
         check(rsp_pa == tlb_pa(va), "R3 tlb pa", rsp_pa, tlb_pa(va));
         check(rsp_fault == va[0], "R3 tlb fault", rsp_fault, va[0]);
         check(req_ready == 1'b1, "R8 ready after rsp", req_ready, 1);
      end
   endtask

   task automatic sweep(input int s, input int e, input int o);
      cfg_write(0, s);
      cfg_write(1, e);
      cfg_write(2, o);
      for (int va = 0; va < NVA; va++) begin
         if (s >= e) check(!exp_hit(va), "R5 empty model", 0, 0);
         xlate(va, va % 3, (va / 3) % 3);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(rsp_valid == 1'b0, "R1 rsp idle", rsp_valid, 0);
      check(tlb_req_valid == 1'b0, "R1 tlb idle", tlb_req_valid, 0);
      check(req_ready == 1'b1, "R1 ready", req_ready, 1);
      // R1: empty window after reset, every address goes to TLB
      xlate(0, 0, 0);
      xlate(NVA - 1, 1, 1);

      sweep(10, 20, 5);          // R2 normal window
      sweep(0, 63, 250);         // R2 wrap of the addition
      sweep(30, 30, 7);          // R5 empty
      sweep(40, 12, 9);          // R5 inverted
      sweep(1, 2, 128);          // single-address window

      // R10: select 3 changes nothing
      sweep(10, 20, 5);
      cfg_write(3, 8'hFF);
      xlate(9, 0, 0);
      xlate(10, 0, 0);
      xlate(19, 0, 0);
      xlate(20, 0, 0);
      check(m_start == 10 && m_end == 20 && m_off == 5, "R10 model kept", m_off, 5);

      // R6: write in the same cycle as an accept uses old offset
      @(negedge clk);
      req_valid = 1'b1; req_va = 6'd12;
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 8'd100;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      check(rsp_valid && rsp_pa == 8'd17, "R6 old offset in flight", rsp_pa, 17);
      m_off = 100;
      xlate(12, 0, 0);
      // R6: end moved in the same cycle, old window still applies
      @(negedge clk);
      req_valid = 1'b1; req_va = 6'd15;
      cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'd14;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      check(rsp_valid && rsp_seg_hit && rsp_pa == 8'd115, "R6 old end in flight", rsp_pa, 115);
      m_end = 14;
      xlate(15, 0, 0);

      // R7: back-to-back hits, one per cycle
      @(negedge clk);
      req_valid = 1'b1; req_va = 6'd10;
      @(negedge clk);
      check(rsp_valid && rsp_pa == 8'd110, "R7 b2b first", rsp_pa, 110);
      check(req_ready == 1'b1, "R7 b2b ready", req_ready, 1);
      req_va = 6'd13;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid && rsp_pa == 8'd113, "R7 b2b second", rsp_pa, 113);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R7 single pulse", rsp_valid, 0);

      // R5: disable at run time returns all to paging
      cfg_write(1, 10);
      xlate(10, 0, 1);
      xlate(12, 1, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule